// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable cell of a logic fabric. A 16-entry look-up table turns four data inputs into one combinational result. An arithmetic mode adds a carry-in and a carry-out, so that adjacent cells can form adder chains. Next to the table sits one storage bit. Static configuration inputs set it to behave as a D, T, JK or SR flip-flop. The same configuration picks its clock from two shared clock lines, its enable from two shared enable lines and its asynchronous clear from two shared clear lines.

The storage bit also has a synchronous clear, a synchronous load from the neighbouring cell's chain output, and a device-wide active-low reset. Its value leaves the cell on a chain output for the next cell. Each of three outputs independently carries either the table result or the stored bit. The register can take its data from a separate input instead of the table, so one cell can hold an unrelated combinational function and an unrelated register at the same time.

Top module: `lec_cell`

## Requirements
- R1: With `cfg_arith`=0, the table result is `cfg_lut[{data[3],data[2],data[1],data[0]}]`. It appears without delay on every output whose select bit is 0, and `cout` is 0.
- R2: With `cfg_arith`=1, the table index is `{data[3],cin,data[1],data[0]}`, so `data[2]` has no effect. `cout` is the majority of `data[0]`, `data[1]` and `cin`.
- R3: Bit i of `cfg_out_sel` chooses the source of `le_out[i]`: 0 gives the table result and 1 gives the stored bit. Each bit is chosen independently.
- R4: With `cfg_mode`=0 (D), the stored bit takes the register data at an enabled rising edge of the selected clock. The register data is `din` when `cfg_din_sel`=1 and the table result when `cfg_din_sel`=0.
- R5: With `cfg_mode`=1 (T), register data 1 inverts the stored bit at an enabled edge and 0 keeps it.
- R6: With `cfg_mode`=2 (JK), J is the register data and K is `din_b`. 00 keeps the bit, 10 sets it, 01 clears it and 11 inverts it.
- R7: With `cfg_mode`=3 (SR), S is the register data and R is `din_b`. 10 sets the bit, 01 clears it, and both 00 and 11 keep it.
- R8: The enable line chosen by `cfg_ena_sel` (0 for `ena0`, 1 for `ena1`) gates every synchronous change. While it is low, an edge leaves the stored bit unchanged, even with `sclr` or `sload` high. The other enable line has no effect.
- R9: At an enabled edge `sclr` has priority over `sload`, and `sload` has priority over the mode update. `sload` copies `chain_in`.
- R10: The stored bit goes to 0 at once, without a clock edge, while `rst_n` is low or while the clear line chosen by `cfg_clr_sel` (0 for `clr0_n`, 1 for `clr1_n`) is low. The other clear line has no effect.
- R11: The stored bit changes only on rising edges of the clock chosen by `cfg_clk_sel` (0 for `clk0`, 1 for `clk1`).
- R12: `chain_out` always equals the stored bit.
- R13: With `cfg_din_sel`=1, the table result and the stored bit drive different outputs at the same time, and neither one disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | Shared clock line 0 |
| clk1 | input | 1 | Shared clock line 1 |
| rst_n | input | 1 | Device-wide reset, active low, asynchronous |
| clr0_n | input | 1 | Shared asynchronous clear line 0, active low |
| clr1_n | input | 1 | Shared asynchronous clear line 1, active low |
| ena0 | input | 1 | Shared clock enable line 0 |
| ena1 | input | 1 | Shared clock enable line 1 |
| sclr | input | 1 | Synchronous clear |
| sload | input | 1 | Synchronous load from `chain_in` |
| data | input | 4 | Table data inputs |
| cin | input | 1 | Carry-in |
| din | input | 1 | Separate register data input (D/T/J/S) |
| din_b | input | 1 | Second register input (K/R) |
| chain_in | input | 1 | Chain output of the previous cell |
| cfg_lut | input | 16 | Table contents |
| cfg_mode | input | 2 | Register mode: 0 D, 1 T, 2 JK, 3 SR |
| cfg_arith | input | 1 | Arithmetic mode enable |
| cfg_din_sel | input | 1 | Register data source: 0 table, 1 `din` |
| cfg_clk_sel | input | 1 | Clock line select |
| cfg_ena_sel | input | 1 | Enable line select |
| cfg_clr_sel | input | 1 | Clear line select |
| cfg_out_sel | input | 3 | Per-output source select: 0 table, 1 register |
| le_out | output | 3 | Cell outputs |
| cout | output | 1 | Carry-out |
| chain_out | output | 1 | Stored bit, to the next cell |

## Verification
Table results and the carry-out are combinational. They are due as soon as the data settles, so the bench drives them and samples 1 ns later with no clock edge in between. A register result is due at the first rising edge of the selected clock after the stimulus. The bench changes inputs 1 ns after one edge of `clk0` and samples 1 ns after the next, so each check sees exactly one register update. Asynchronous clears are checked 1 ns after the line falls, well before any edge. The clock-select case pulses `clk1` by hand between `clk0` edges, and it switches the select only while no false rising edge can appear.

// File: rtl/lec_pkg.sv
// Package: shared types for the configurable logic cell.
// Assumes: the mode encoding below is the one driven on cfg_mode.
package lec_pkg;
    typedef enum logic [1:0] {
        MODE_D  = 2'd0,
        MODE_T  = 2'd1,
        MODE_JK = 2'd2,
        MODE_SR = 2'd3
    } reg_mode_e;
endpackage

// File: rtl/lec_lut.sv
// Module: look-up table with optional arithmetic carry.
// Assumes: N_IN >= 3. In arithmetic mode the carry-in replaces input 2 of
// the index, and carry-out is the majority of inputs 0, 1 and carry-in.
module lec_lut #(
    parameter int unsigned N_IN = 4
) (
    input  logic [(1<<N_IN)-1:0] table_bits,
    input  logic [N_IN-1:0]      sel_in,
    input  logic                 arith,
    input  logic                 cin,
    output logic                 f,
    output logic                 cout
);
    logic [N_IN-1:0] idx;

    // Build the table index, with the carry taking input 2's place in arithmetic mode.
    always_comb begin
        idx = sel_in;
        if (arith) idx[2] = cin;
    end

    // Read the table and form the carry-out.
    always_comb begin
        f    = table_bits[idx];
        cout = arith & ((sel_in[0] & sel_in[1]) | (cin & (sel_in[0] | sel_in[1])));
    end
endmodule

// File: rtl/lec_ctrl_sel.sv
// Module: picks one clock, one enable and one clear from the shared lines.
// Assumes: configuration selects are static while the cell runs. The
// device reset and the selected clear combine into one active-low clear.
module lec_ctrl_sel #(
    parameter int unsigned NUM_LINES = 2,
    localparam int unsigned SEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0] clk_lines,
    input  logic [NUM_LINES-1:0] ena_lines,
    input  logic [NUM_LINES-1:0] clr_n_lines,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     clk_sel,
    input  logic [SEL_W-1:0]     ena_sel,
    input  logic [SEL_W-1:0]     clr_sel,
    output logic                 clk_o,
    output logic                 ena_o,
    output logic                 arst_n_o
);
    // Route the chosen lines to the register.
    always_comb begin
        clk_o    = clk_lines[clk_sel];
        ena_o    = ena_lines[ena_sel];
        arst_n_o = rst_n & clr_n_lines[clr_sel];
    end
endmodule

// File: rtl/lec_ff.sv
// Module: programmable storage bit (D, T, JK, SR) with clears and load.
// Assumes: arst_n clears asynchronously. The enable gates the synchronous
// clear, the load and the mode update, in that priority order.
module lec_ff
    import lec_pkg::*;
(
    input  logic      clk,
    input  logic      arst_n,
    input  logic      ena,
    input  logic      sclr,
    input  logic      sload,
    input  logic      chain_in,
    input  reg_mode_e mode,
    input  logic      a,
    input  logic      b,
    output logic      q
);
    logic next_q;

    // Compute the mode-dependent next value from inputs a (D/T/J/S) and b (K/R).
    always_comb begin
        unique case (mode)
            MODE_D:  next_q = a;
            MODE_T:  next_q = q ^ a;
            MODE_JK: next_q = (a & ~q) | (~b & q);
            MODE_SR: next_q = (a & ~b) ? 1'b1 : ((~a & b) ? 1'b0 : q);
            default: next_q = q;
        endcase
    end

    // Storage bit with asynchronous clear and prioritised synchronous controls.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)     q <= 1'b0;
        else if (ena) begin
            if (sclr)       q <= 1'b0;
            else if (sload) q <= chain_in;
            else            q <= next_q;
        end
    end

    AST_SCLR_WINS:   assert property (@(posedge clk) disable iff (!arst_n) ena && sclr |=> !q); // R9
    AST_SLOAD_CHAIN: assert property (@(posedge clk) disable iff (!arst_n) ena && !sclr && sload |=> q == $past(chain_in)); // R9
    AST_ENA_HOLD:    assert property (@(posedge clk) disable iff (!arst_n) !ena |=> $stable(q)); // R8
    AST_T_TOGGLE:    assert property (@(posedge clk) disable iff (!arst_n) ena && !sclr && !sload && mode == MODE_T && a |=> q != $past(q)); // R5
    AST_JK_TOGGLE:   assert property (@(posedge clk) disable iff (!arst_n) ena && !sclr && !sload && mode == MODE_JK && a && b |=> q != $past(q)); // R6
    AST_SR_BOTH:     assert property (@(posedge clk) disable iff (!arst_n) ena && !sclr && !sload && mode == MODE_SR && a && b |=> $stable(q)); // R7
    AST_ASYNC_CLEAR: assert property (@(posedge clk) !arst_n |-> !q); // R10
endmodule

// File: rtl/lec_outmux.sv
// Module: per-output source selection between table and register.
// Assumes: one select bit per output; 1 picks the register.
module lec_outmux #(
    parameter int unsigned NUM_OUT = 3
) (
    input  logic [NUM_OUT-1:0] out_sel,
    input  logic               lut_f,
    input  logic               reg_q,
    output logic [NUM_OUT-1:0] outs
);
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        // Steer output i to its chosen source.
        always_comb outs[i] = out_sel[i] ? reg_q : lut_f;
    end
endmodule

// File: rtl/lec_cell.sv
// Module: top of the configurable logic cell.
// Assumes: configuration inputs are static. Clock selects change only while
// both candidate clocks are low, so no false edge reaches the register.
module lec_cell
    import lec_pkg::*;
#(
    parameter int unsigned LUT_IN  = 4,
    parameter int unsigned NUM_OUT = 3,
    localparam int unsigned LUT_SIZE = 1 << LUT_IN
) (
    input  logic                clk0,
    input  logic                clk1,
    input  logic                rst_n,
    input  logic                clr0_n,
    input  logic                clr1_n,
    input  logic                ena0,
    input  logic                ena1,
    input  logic                sclr,
    input  logic                sload,
    input  logic [LUT_IN-1:0]   data,
    input  logic                cin,
    input  logic                din,
    input  logic                din_b,
    input  logic                chain_in,
    input  logic [LUT_SIZE-1:0] cfg_lut,
    input  logic [1:0]          cfg_mode,
    input  logic                cfg_arith,
    input  logic                cfg_din_sel,
    input  logic                cfg_clk_sel,
    input  logic                cfg_ena_sel,
    input  logic                cfg_clr_sel,
    input  logic [NUM_OUT-1:0]  cfg_out_sel,
    output logic [NUM_OUT-1:0]  le_out,
    output logic                cout,
    output logic                chain_out
);
    logic lut_f;
    logic reg_clk;
    logic reg_ena;
    logic reg_arst_n;
    logic reg_a;
    logic reg_q;

    lec_lut #(.N_IN(LUT_IN)) u_lut (
        .table_bits (cfg_lut),
        .sel_in     (data),
        .arith      (cfg_arith),
        .cin        (cin),
        .f          (lut_f),
        .cout       (cout)
    );

    lec_ctrl_sel #(.NUM_LINES(2)) u_ctrl (
        .clk_lines   ({clk1, clk0}),
        .ena_lines   ({ena1, ena0}),
        .clr_n_lines ({clr1_n, clr0_n}),
        .rst_n       (rst_n),
        .clk_sel     (cfg_clk_sel),
        .ena_sel     (cfg_ena_sel),
        .clr_sel     (cfg_clr_sel),
        .clk_o       (reg_clk),
        .ena_o       (reg_ena),
        .arst_n_o    (reg_arst_n)
    );

    // Choose register data: the separate input allows packing unrelated logic.
    always_comb reg_a = cfg_din_sel ? din : lut_f;

    lec_ff u_ff (
        .clk      (reg_clk),
        .arst_n   (reg_arst_n),
        .ena      (reg_ena),
        .sclr     (sclr),
        .sload    (sload),
        .chain_in (chain_in),
        .mode     (reg_mode_e'(cfg_mode)),
        .a        (reg_a),
        .b        (din_b),
        .q        (reg_q)
    );

    lec_outmux #(.NUM_OUT(NUM_OUT)) u_out (
        .out_sel (cfg_out_sel),
        .lut_f   (lut_f),
        .reg_q   (reg_q),
        .outs    (le_out)
    );

    // Present the stored bit to the next cell.
    always_comb chain_out = reg_q;
endmodule

// File: tb/tb_lec_cell.sv
// Bench: a vector table for the table and carry, then directed register tests.
module tb_lec_cell;
    logic       clk0 = 1'b0, clk1 = 1'b0, rst_n = 1'b0;
    logic       clr0_n = 1'b1, clr1_n = 1'b1, ena0 = 1'b1, ena1 = 1'b0;
    logic       sclr = 1'b0, sload = 1'b0, cin = 1'b0, din = 1'b0, din_b = 1'b0, chain_in = 1'b0;
    logic [3:0] data = 4'h0;
    logic [15:0] cfg_lut = 16'h0;
    logic [1:0] cfg_mode = 2'd0;
    logic       cfg_arith = 1'b0, cfg_din_sel = 1'b1, cfg_clk_sel = 1'b0;
    logic       cfg_ena_sel = 1'b0, cfg_clr_sel = 1'b0;
    logic [2:0] cfg_out_sel = 3'b110;
    logic [2:0] le_out;
    logic       cout, chain_out;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    lec_cell dut (.*);

    always #2.5 clk0 = ~clk0;

    // Vectors: table, arith, data, cin, expected result, expected carry.
    localparam int NV = 10;
    localparam logic [15:0] V_LUT  [NV] = '{16'h8000, 16'h8000, 16'hFFFE, 16'hFFFE, 16'h6996,
                                            16'h9696, 16'h9696, 16'h9696, 16'h9696, 16'h0001};
    localparam logic        V_AR   [NV] = '{0, 0, 0, 0, 0, 1, 1, 1, 0, 0};
    localparam logic [3:0]  V_DAT  [NV] = '{4'hF, 4'hE, 4'h0, 4'h4, 4'h7, 4'h3, 4'h1, 4'h6, 4'h0, 4'h0};
    localparam logic        V_CIN  [NV] = '{0, 0, 0, 0, 0, 1, 0, 1, 1, 0};
    localparam logic        V_F    [NV] = '{1, 0, 0, 1, 1, 1, 1, 0, 0, 1};
    localparam logic        V_CO   [NV] = '{0, 0, 0, 0, 0, 1, 0, 1, 0, 0};

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Stored bit seen on chain_out and on register-selected le_out[1].
    task automatic chkq(input string req, input logic e);
        chk(req, {2'b00, le_out[1], chain_out}, {2'b00, e, e});
    endtask

    task automatic tick();
        @(posedge clk0);
        #1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset state (R10): device reset holds the bit at 0.
        tick(); tick();
        chkq("R10 reset", 1'b0);
        chk("R12 reset chain", {3'b000, chain_out}, 4'h0);

        // Table and carry vectors (R1, R2, R3: le_out[0] selects table).
        for (int i = 0; i < NV; i++) begin
            cfg_lut = V_LUT[i]; cfg_arith = V_AR[i]; data = V_DAT[i]; cin = V_CIN[i];
            #1;
            chk(V_AR[i] ? "R2 result" : "R1 result", {3'b000, le_out[0]}, {3'b000, V_F[i]});
            chk(V_AR[i] ? "R2 carry" : "R1 carry", {3'b000, cout}, {3'b000, V_CO[i]});
        end
        cfg_arith = 1'b0;

        // D mode from din (R4).
        tick(); rst_n = 1'b1;
        din = 1'b1; tick(); chkq("R4 d1", 1'b1);
        din = 1'b0; tick(); chkq("R4 d0", 1'b0);
        din = 1'b1; tick(); chkq("R4 d1b", 1'b1);

        // Packing (R13, R3): table on out0, register on out1/out2.
        cfg_lut = 16'h8000; data = 4'h0; #1;
        chk("R13 pack a", {1'b0, le_out}, 4'b0110);
        data = 4'hF; din = 1'b0; #1;
        chk("R13 pack b", {1'b0, le_out}, 4'b0111);
        tick();
        chk("R3 pack c", {1'b0, le_out}, 4'b0001);

        // Enable gating (R8).
        din = 1'b1; tick(); chkq("R8 setup", 1'b1);
        ena0 = 1'b0; ena1 = 1'b1; din = 1'b0; sclr = 1'b1; tick();
        chkq("R8 held", 1'b1);
        sclr = 1'b0; cfg_ena_sel = 1'b1; tick();
        chkq("R8 line1", 1'b0);
        cfg_ena_sel = 1'b0; ena0 = 1'b1; ena1 = 1'b0;

        // Priority and load (R9).
        chain_in = 1'b1; sload = 1'b1; din = 1'b0; tick(); chkq("R9 load", 1'b1);
        sclr = 1'b1; tick(); chkq("R9 sclr wins", 1'b0);
        sclr = 1'b0; sload = 1'b0; chain_in = 1'b0;

        // T mode (R5).
        cfg_mode = 2'd1; din = 1'b1; tick(); chkq("R5 t1", 1'b1);
        tick(); chkq("R5 t2", 1'b0);
        din = 1'b0; tick(); chkq("R5 hold", 1'b0);
        din = 1'b1; tick(); chkq("R5 t3", 1'b1);

        // JK mode (R6), q=1.
        cfg_mode = 2'd2;
        din = 1'b0; din_b = 1'b0; tick(); chkq("R6 hold", 1'b1);
        din = 1'b0; din_b = 1'b1; tick(); chkq("R6 clear", 1'b0);
        din = 1'b1; din_b = 1'b0; tick(); chkq("R6 set", 1'b1);
        din = 1'b1; din_b = 1'b1; tick(); chkq("R6 toggle", 1'b0);
        tick(); chkq("R6 toggle2", 1'b1);

        // SR mode (R7), q=1.
        cfg_mode = 2'd3;
        din = 1'b0; din_b = 1'b1; tick(); chkq("R7 reset", 1'b0);
        din = 1'b1; din_b = 1'b1; tick(); chkq("R7 both0", 1'b0);
        din = 1'b1; din_b = 1'b0; tick(); chkq("R7 set", 1'b1);
        din = 1'b1; din_b = 1'b1; tick(); chkq("R7 both1", 1'b1);
        din = 1'b0; din_b = 1'b0; tick(); chkq("R7 none", 1'b1);

        // D mode fed from the table (R4).
        cfg_mode = 2'd0; din_b = 1'b0; cfg_din_sel = 1'b0; cfg_lut = 16'h8000;
        data = 4'h0; tick(); chkq("R4 lut0", 1'b0);
        data = 4'hF; tick(); chkq("R4 lut1", 1'b1);
        cfg_din_sel = 1'b1; din = 1'b1;

        // Asynchronous clears (R10).
        #1; clr1_n = 1'b0; #1; chkq("R10 other line", 1'b1);
        clr1_n = 1'b1; clr0_n = 1'b0; #1; chkq("R10 line0", 1'b0);
        tick(); chkq("R10 held", 1'b0);
        clr0_n = 1'b1; tick(); chkq("R10 release", 1'b1);
        cfg_clr_sel = 1'b1; clr1_n = 1'b0; #1; chkq("R10 line1", 1'b0);
        clr1_n = 1'b1; tick(); chkq("R10 release1", 1'b1);
        rst_n = 1'b0; #1; chkq("R10 device", 1'b0);
        rst_n = 1'b1; cfg_clr_sel = 1'b0;
        tick(); chkq("R12 after", 1'b1);

        // Clock select (R11).
        din = 1'b0; cfg_clk_sel = 1'b1; tick();
        chkq("R11 clk0 ignored", 1'b1);
        clk1 = 1'b1; #1; chkq("R11 clk1 edge", 1'b0);
        clk1 = 1'b0;
        @(negedge clk0); cfg_clk_sel = 1'b0;
        din = 1'b1; tick(); chk("R12 chain", {3'b000, chain_out}, 4'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule